// File: doc/BRIEF.md
# Programmable AND-Plane Sum-of-Products Array

This block is a small sum-of-products array with a configurable AND plane and a hard-wired OR plane. Each primary input drives two literals: its true value and its complement. A configuration register holds one connect bit for every crosspoint between a literal and a product term. When a bit is set, its switch is closed and the literal joins that term's AND. When the bit is clear, the switch is open and the literal has no effect.

The OR plane cannot be changed. Output 0 is term 0 OR term 1, and output 1 is term 1 OR term 2, so the middle term feeds both outputs. A function that needs more terms than this arrangement offers cannot be built, and no term can be borrowed from elsewhere.

The configuration is written in parallel on a write strobe at a clock edge. It is volatile and is cleared by reset. The data path from the inputs through to the outputs has no clock.

Top module: `pal_array`

## Requirements
- R1: While reset is asserted, the configuration register is cleared to all zeros. Once reset is released, every term is therefore empty and both outputs read 1 for every input value.
- R2: When `cfg_we` is low at a rising clock edge, the configuration keeps its value whatever is on `cfg_data`.
- R3: Term t uses configuration bits [4t+3:4t]. Within that group, bit 0 connects input 0 true, bit 1 connects input 0 complemented, bit 2 connects input 1 true and bit 3 connects input 1 complemented. The term is the AND of all connected literals.
- R4: A term with no connected literal evaluates to 1.
- R5: A term that has both a literal and its complement connected evaluates to 0 for every input value.
- R6: `z_out[0]` is term 0 OR term 1, and `z_out[1]` is term 1 OR term 2. Term 1 is shared by both outputs.
- R7: The outputs follow an input change within the same clock cycle, without waiting for a clock edge.
- R8: A value written with `cfg_we` high takes effect only after the rising edge. Before that edge, the outputs still follow the previous configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset that clears the configuration |
| cfg_we | input | 1 | Parallel configuration write strobe |
| cfg_data | input | 12 | Connect bits to load, 4 per term |
| din | input | 2 | Primary inputs |
| z_out | output | 2 | Outputs of the fixed OR plane |

## Verification
The bench builds the array with its default sizes: two inputs and three terms, which gives a 12-bit configuration and two outputs. At that size every input combination can be applied under each configuration tested. The configurations cover the case where no term is connected, a two-output decode that uses all three terms, contradictory literal pairs, and a shared middle term that forces both outputs high. A write is checked on both sides of its clock edge, and the hold case is checked against a changing `cfg_data` bus.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic {
        POL_TRUE = 1'b0,
        POL_COMP = 1'b1
    } lit_pol_e;

    // Position of a literal inside one term's connect group
    function automatic int lit_index(input int in_idx, input lit_pol_e pol);
        return 2 * in_idx + ((pol == POL_COMP) ? 1 : 0);
    endfunction

endpackage

// File: rtl/pal_cfg_reg.sv
module pal_cfg_reg #(
    parameter int CFG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] d,
    output logic [CFG_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(d)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane
    import pal_pkg::*;
#(
    parameter int N_IN = 2,
    parameter int N_PT = 3
) (
    input  logic [N_PT*2*N_IN-1:0] cfg,
    input  logic [N_IN-1:0]        din,
    output logic [N_PT-1:0]        pt
);

    localparam int N_LIT = 2 * N_IN;

    logic [N_LIT-1:0] lits;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lits[lit_index(i, POL_TRUE)] = din[i];
        assign lits[lit_index(i, POL_COMP)] = ~din[i];
    end

    // An open switch lets its line float high, so it cannot pull the AND low.
    for (genvar t = 0; t < N_PT; t++) begin : g_term
        assign pt[t] = &(lits | ~cfg[t*N_LIT +: N_LIT]);
    end

endmodule

// File: rtl/pal_or_plane.sv
module pal_or_plane #(
    parameter int N_PT = 3
) (
    input  logic [N_PT-1:0] pt,
    output logic [N_PT-2:0] z
);

    // Fixed wiring: each output joins neighbouring terms.
    for (genvar k = 0; k < N_PT - 1; k++) begin : g_sum
        assign z[k] = pt[k] | pt[k+1];
    end

endmodule

// File: rtl/pal_array.sv
module pal_array #(
    parameter int N_IN = 2,
    parameter int N_PT = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [N_PT*2*N_IN-1:0] cfg_data,
    input  logic [N_IN-1:0]        din,
    output logic [N_PT-2:0]        z_out
);

    localparam int N_LIT = 2 * N_IN;
    localparam int CFG_W = N_PT * N_LIT;

    logic [CFG_W-1:0] cfg_q;
    logic [N_PT-1:0]  pt;

    pal_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cfg_we),
        .d    (cfg_data),
        .q    (cfg_q)
    );

    pal_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
        .cfg(cfg_q),
        .din(din),
        .pt (pt)
    );

    pal_or_plane #(.N_PT(N_PT)) u_or (
        .pt(pt),
        .z (z_out)
    );

    for (genvar t = 0; t < N_PT; t++) begin : g_chk
        assert_empty_term_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[t*N_LIT +: N_LIT] == '0) |-> pt[t]);
        for (genvar i = 0; i < N_IN; i++) begin : g_in
            assert_contra_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_q[t*N_LIT + 2*i] && cfg_q[t*N_LIT + 2*i + 1]) |-> !pt[t]);
            assert_true_lit_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_q[t*N_LIT + 2*i] && !din[i]) |-> !pt[t]);
        end
    end

    assert_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pt[1] |-> (z_out[0] && z_out[N_PT-2]));

    assert_low_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pt[0] && !pt[1]) |-> !z_out[0]);

endmodule

// File: tb/pal_array_tb.sv
`timescale 1ns/100ps
module pal_array_tb;

    typedef struct {
        logic [1:0] exp_z;
        string      req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_data = '0;
    logic [1:0]  din = '0;
    logic [1:0]  z_out;

    int checks = 0;
    int errors = 0;
    item_t sb_q[$];
    event  drv_ev;

    always #2 clk = ~clk;

    pal_array u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_data(cfg_data),
        .din     (din),
        .z_out   (z_out)
    );

    // Expected outputs derived from the requirement bit layout (R3, R4, R6)
    function automatic logic [1:0] model(input logic [11:0] c, input logic [1:0] d);
        logic [2:0] p;
        for (int t = 0; t < 3; t++) begin
            p[t] = 1'b1;
            for (int l = 0; l < 4; l++) begin
                logic lv;
                lv = l[0] ? ~d[l>>1] : d[l>>1];
                if (c[4*t+l] && !lv) p[t] = 1'b0;
            end
        end
        return {p[1] | p[2], p[0] | p[1]};
    endfunction

    task automatic drive(input logic [1:0] d, input logic [1:0] exp_z, input string req);
        item_t it;
        din = d;
        it.exp_z = exp_z;
        it.req = req;
        sb_q.push_back(it);
        -> drv_ev;
        #1;
    endtask

    task automatic write_cfg(input logic [11:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_data = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic sweep(input logic [11:0] c, input string req);
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            drive(v[1:0], model(c, v[1:0]), req);
        end
    endtask

    // Monitor: pops expected items and compares them to the outputs
    initial begin
        forever begin
            @(drv_ev);
            #0.5;
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL %s: scoreboard empty, actual %b expected none", "R0", z_out);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                if (z_out !== it.exp_z) begin
                    errors++;
                    $display("FAIL %s: din=%b actual %b expected %b", it.req, din, z_out, it.exp_z);
                end
            end
        end
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cfg_we = 1'b1;
        cfg_data = 12'hFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        rst_n = 1'b1;

        // R1 / R4: cleared configuration, all terms empty
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            drive(v[1:0], 2'b11, "R1");
        end

        // R3 / R6: term0 = in0 & ~in1, term1 = ~in0 & in1, term2 = in0 & in1
        write_cfg(12'h569);
        sweep(12'h569, "R3");
        @(negedge clk);
        drive(2'b11, 2'b10, "R6");
        @(negedge clk);
        drive(2'b00, 2'b00, "R6");

        // R7: output follows an input change within one cycle
        @(negedge clk);
        din = 2'b01;
        #0.5;
        drive(2'b10, 2'b11, "R7");

        // R8: pending write has no effect before the edge
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_data = 12'h000;
        drive(2'b00, 2'b00, "R8");
        @(negedge clk);
        cfg_we = 1'b0;
        drive(2'b00, 2'b11, "R8");

        // R2: strobe low, bus changes, configuration held
        write_cfg(12'h569);
        @(negedge clk);
        cfg_data = 12'hFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cfg_data = 12'h000;
        repeat (2) @(posedge clk);
        sweep(12'h569, "R2");

        // R5: contradictory pairs in terms 0 and 1, term 2 empty
        write_cfg(12'h0C3);
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            drive(v[1:0], 2'b10, "R5");
        end

        // R4 / R6: empty shared middle term forces both outputs high
        write_cfg(12'hC0C);
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            drive(v[1:0], 2'b11, "R4");
        end

        // R3: complement literal alone in term 2
        write_cfg(12'h2CC);
        sweep(12'h2CC, "R3");

        @(negedge clk);
        #1;
        if (sb_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R0: leftover items actual %0d expected 0", sb_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule